// File: doc/BRIEF.md
# MDIO PHY Auto-Configuration Sequencer

This block is a management master that configures a range of Ethernet PHYs on its own, without any host in the loop. After a start pulse it walks through the PHY addresses from a first to a last address. For each PHY it sends three clause 22 write frames over the two-wire management bus. The first two frames load the two advertised-ability words into registers 4 and 5. The third sets the enable and restart bits of the control register, so the PHY negotiates again with the new abilities.

The management clock (MDC) is derived from the system clock by an even divider. MDC runs freely from reset. Data leaves the block on the falling MDC edge, so it is settled when a PHY samples it on the rising edge. The data output is only enabled while a frame is on the wire. A done flag reports that the last PHY has been handled and stays up until the next start. Reading status back from the PHYs is not part of this block.

Top module: `mdio_autocfg`

## Requirements
- R1: Every frame is 64 MDC bits sent MSB first, in this order: 32 ones, start code 01, write opcode 01, 5-bit PHY address, 5-bit register address, turnaround 10, and 16 data bits.
- R2: For each PHY, the first frame writes register 4 with the `adv_a_i` word and the second frame writes register 5 with the `adv_b_i` word. Both words are captured at start.
- R3: The third frame for each PHY writes register 0 with 16'h1200, which sets bit 12 (negotiation enable) and bit 9 (restart).
- R4: PHYs are visited in ascending address order, from `phy_first_i` to `phy_last_i`. The address wraps from 31 to 0. Exactly three frames are sent per PHY.
- R5: The MDC period is CLK_DIV system clocks, with CLK_DIV/2 clocks high and CLK_DIV/2 clocks low.
- R6: MDIO data and output-enable change only in the system clock in which MDC falls. They never change while MDC is high.
- R7: Output-enable is low outside frames. At least one MDC rising edge with output-enable low separates consecutive frames.
- R8: `done_o` rises after the last frame of the last PHY and then holds. It is low while a sequence runs. A start pulse in the done state begins a new sequence.
- R9: A start pulse while a sequence is running is ignored. Addresses and ability words also stay as they were captured.
- R10: During and right after reset, MDC, output-enable and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle start pulse |
| adv_a_i | input | 16 | Ability word for register 4 |
| adv_b_i | input | 16 | Ability word for register 5 |
| phy_first_i | input | 5 | First PHY address |
| phy_last_i | input | 5 | Last PHY address |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| done_o | output | 1 | Sequence complete |

## Verification
A data bit is launched in the clock where MDC falls. It is due at the next MDC rise, CLK_DIV/2 system clocks later. The bench therefore decodes frames on MDC rising edges, as a PHY would, and never samples on system clock edges where the data changes. The done flag is due in the clock where the final frame's last bit ends. The bench polls it on falling system clock edges within a bound of three frames of 68 MDC periods per PHY. It then waits further MDC periods to prove that no extra frame follows. Edge placement and the MDC duty cycle are checked clock by clock on falling system clock edges.

// File: rtl/mdio_autocfg_pkg.sv
package mdio_autocfg_pkg;
   localparam int PHY_AW = 5;
   localparam int REG_AW = 5;
   localparam int DATA_W = 16;
   localparam int HDR_W  = 2 + 2 + PHY_AW + REG_AW + 2;

   localparam logic [1:0] SOF_CODE = 2'b01;
   localparam logic [1:0] OP_WRITE = 2'b01;
   localparam logic [1:0] TA_WRITE = 2'b10;

   localparam logic [REG_AW-1:0] REG_CTRL = 5'd0;
   localparam logic [REG_AW-1:0] REG_ADVA = 5'd4;
   localparam logic [REG_AW-1:0] REG_ADVB = 5'd5;
   localparam logic [DATA_W-1:0] CTRL_RENEG = 16'h1200;

   typedef enum logic [1:0] {STEP_ADVA, STEP_ADVB, STEP_RENEG} step_e;
   typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_DONE} seq_e;
   typedef enum logic [1:0] {TX_IDLE, TX_SHIFT, TX_GAP} tx_e;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
   parameter int CLK_DIV = 20
) (
   input  logic clk,
   input  logic rst_n,
   output logic mdc_o,
   output logic fall_tick_o
);
   localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
   localparam int HALF = CLK_DIV / 2;
   localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);
   localparam logic [CW-1:0] RISE = CW'(HALF - 1);

   logic [CW-1:0] cnt_q;
   logic          mdc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (cnt_q == LAST) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == RISE) mdc_q <= 1'b1;
      end
   end

   assign mdc_o       = mdc_q;
   assign fall_tick_o = (cnt_q == LAST);
endmodule

// File: rtl/mdio_frame_tx.sv
module mdio_frame_tx
   import mdio_autocfg_pkg::*;
#(
   parameter int PRE_LEN = 32,
   parameter int GAP_MDC = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              go_i,
   input  logic [PHY_AW-1:0] phy_i,
   input  logic [REG_AW-1:0] reg_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              mdio_o,
   output logic              oe_o,
   output logic              fin_o
);
   localparam int FRAME_W = PRE_LEN + HDR_W + DATA_W;
   localparam int BW      = $clog2(FRAME_W);
   localparam int GW      = (GAP_MDC > 1) ? $clog2(GAP_MDC) : 1;
   localparam logic [BW-1:0] BIT_LAST = BW'(FRAME_W - 1);
   localparam logic [GW-1:0] GAP_LAST = GW'(GAP_MDC - 1);

   tx_e                st_q;
   logic [FRAME_W-1:0] sh_q;
   logic [BW-1:0]      bit_q;
   logic [GW-1:0]      gap_q;
   logic               oe_q;
   logic               fin_q;
   logic [FRAME_W-1:0] frame_c;

   assign frame_c = {{PRE_LEN{1'b1}}, SOF_CODE, OP_WRITE, phy_i, reg_i, TA_WRITE, data_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= TX_IDLE;
         sh_q  <= '0;
         bit_q <= '0;
         gap_q <= '0;
         oe_q  <= 1'b0;
         fin_q <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         if (tick_i) begin
            unique case (st_q)
               TX_IDLE: if (go_i) begin
                  sh_q  <= frame_c;
                  bit_q <= '0;
                  oe_q  <= 1'b1;
                  st_q  <= TX_SHIFT;
               end
               TX_SHIFT: if (bit_q == BIT_LAST) begin
                  oe_q  <= 1'b0;
                  fin_q <= 1'b1;
                  gap_q <= '0;
                  st_q  <= TX_GAP;
               end else begin
                  sh_q  <= sh_q << 1;
                  bit_q <= bit_q + 1'b1;
               end
               TX_GAP: if (gap_q == GAP_LAST) st_q <= TX_IDLE;
                       else gap_q <= gap_q + 1'b1;
               default: st_q <= TX_IDLE;
            endcase
         end
      end
   end

   assign mdio_o = oe_q & sh_q[FRAME_W-1];
   assign oe_o   = oe_q;
   assign fin_o  = fin_q;
endmodule

// File: rtl/mdio_autocfg.sv
module mdio_autocfg
   import mdio_autocfg_pkg::*;
#(
   parameter int CLK_DIV = 20,
   parameter int PRE_LEN = 32,
   parameter int GAP_MDC = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  logic [15:0] adv_a_i,
   input  logic [15:0] adv_b_i,
   input  logic [4:0]  phy_first_i,
   input  logic [4:0]  phy_last_i,
   output logic        mdc_o,
   output logic        mdio_o,
   output logic        mdio_oe_o,
   output logic        done_o
);
   generate
      if (CLK_DIV < 4 || (CLK_DIV % 2) != 0) begin : g_bad_div
         initial $fatal(1, "CLK_DIV must be even and at least 4");
      end
      if (PRE_LEN < 1 || GAP_MDC < 1) begin : g_bad_frame
         initial $fatal(1, "PRE_LEN and GAP_MDC must be at least 1");
      end
   endgenerate

   logic              tick;
   logic              fin;
   seq_e              sq_q;
   step_e             step_q;
   logic [PHY_AW-1:0] phy_q, last_q;
   logic [DATA_W-1:0] adva_q, advb_q;
   logic [REG_AW-1:0] reg_c;
   logic [DATA_W-1:0] data_c;

   mdio_mdc_gen #(.CLK_DIV(CLK_DIV)) u_mdc (
      .clk(clk), .rst_n(rst_n), .mdc_o(mdc_o), .fall_tick_o(tick)
   );

   always_comb begin
      unique case (step_q)
         STEP_ADVA: begin reg_c = REG_ADVA; data_c = adva_q;     end
         STEP_ADVB: begin reg_c = REG_ADVB; data_c = advb_q;     end
         default:   begin reg_c = REG_CTRL; data_c = CTRL_RENEG; end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sq_q   <= SQ_IDLE;
         step_q <= STEP_ADVA;
         phy_q  <= '0;
         last_q <= '0;
         adva_q <= '0;
         advb_q <= '0;
      end else if (sq_q != SQ_RUN) begin
         if (start_i) begin
            sq_q   <= SQ_RUN;
            step_q <= STEP_ADVA;
            phy_q  <= phy_first_i;
            last_q <= phy_last_i;
            adva_q <= adv_a_i;
            advb_q <= adv_b_i;
         end
      end else if (fin) begin
         unique case (step_q)
            STEP_ADVA: step_q <= STEP_ADVB;
            STEP_ADVB: step_q <= STEP_RENEG;
            default: begin
               step_q <= STEP_ADVA;
               if (phy_q == last_q) sq_q <= SQ_DONE;
               else                 phy_q <= phy_q + 1'b1;
            end
         endcase
      end
   end

   mdio_frame_tx #(.PRE_LEN(PRE_LEN), .GAP_MDC(GAP_MDC)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .go_i(sq_q == SQ_RUN),
      .phy_i(phy_q), .reg_i(reg_c), .data_i(data_c),
      .mdio_o(mdio_o), .oe_o(mdio_oe_o), .fin_o(fin)
   );

   assign done_o = (sq_q == SQ_DONE);
endmodule

// File: rtl/mdio_autocfg_chk.sv
module mdio_autocfg_chk #(
   parameter int CLK_DIV = 20
) (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic mdc_o,
   input logic mdio_o,
   input logic mdio_oe_o,
   input logic done_o
);
   logic [15:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hi_cnt <= '0;
      else if (mdc_o) hi_cnt <= hi_cnt + 1'b1;
      else            hi_cnt <= '0;
   end

   AST_MDC_HIGH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mdc_o) |-> (hi_cnt == 16'(CLK_DIV / 2))); // R5

   AST_DATA_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mdio_o) |-> $fell(mdc_o)); // R6

   AST_OE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mdio_oe_o) |-> $fell(mdc_o)); // R6

   AST_OE_OFF_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !mdio_oe_o); // R7

   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> done_o); // R8

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> (!mdc_o && !mdio_oe_o && !done_o)); // R10
endmodule

bind mdio_autocfg mdio_autocfg_chk #(.CLK_DIV(CLK_DIV)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .mdc_o(mdc_o),
   .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .done_o(done_o)
);

// File: tb/mdio_autocfg_bench.sv
module mdio_autocfg_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [15:0] adv_a_i = '0, adv_b_i = '0;
   logic [4:0]  phy_first_i = '0, phy_last_i = '0;
   logic        mdc_o, mdio_o, mdio_oe_o, done_o;

   int total = 0, bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   mdio_autocfg #(.CLK_DIV(DIV)) u_mdio_autocfg (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .adv_a_i(adv_a_i), .adv_b_i(adv_b_i),
      .phy_first_i(phy_first_i), .phy_last_i(phy_last_i),
      .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .done_o(done_o)
   );

   // PHY-side frame decoder on MDC rising edges
   logic [63:0] mon_sh = '0;
   logic [63:0] frames [0:63];
   int mon_n = 0, nfr = 0, gap_bad = 0;
   bit prev_oe_rise = 1'b0;

   always @(posedge mdc_o) begin
      if (mdio_oe_o) begin
         if (mon_n == 0 && prev_oe_rise) gap_bad++;
         mon_sh = {mon_sh[62:0], mdio_o};
         mon_n++;
         if (mon_n == 64) begin
            if (nfr < 64) frames[nfr] = mon_sh;
            nfr++;
            mon_n = 0;
         end
      end else if (mon_n != 0) begin
         gap_bad++;
         mon_n = 0;
      end
      prev_oe_rise = mdio_oe_o;
   end

   // Clock-by-clock edge and duty monitor
   bit p_mdc = 1'b0, p_mdio = 1'b0, p_oe = 1'b0;
   int since_rise = -1, hi_len = 0, stab_bad = 0, period_bad = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (mdc_o && p_mdc && (mdio_o != p_mdio || mdio_oe_o != p_oe)) stab_bad++;
         if (mdc_o && !p_mdc) begin
            if (since_rise >= 0 && since_rise != DIV) period_bad++;
            since_rise = 1;
         end else if (since_rise >= 0) since_rise++;
         if (mdc_o) hi_len++;
         else begin
            if (p_mdc && hi_len != DIV / 2) period_bad++;
            hi_len = 0;
         end
      end
      p_mdc = mdc_o; p_mdio = mdio_o; p_oe = mdio_oe_o;
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic run_seq(input logic [4:0] first, input logic [4:0] last,
                          input logic [15:0] a, input logic [15:0] b, input bit inject);
      int base, nphy, limit, waited;
      nphy  = int'((last - first) & 5'h1f) + 1;
      limit = nphy * 3 * 68 * DIV + 200;
      @(negedge clk);
      base = nfr;
      phy_first_i = first; phy_last_i = last; adv_a_i = a; adv_b_i = b;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (2) @(negedge clk);
      chk(!done_o, "R8 done low while running", 64'(done_o), 64'd0);
      if (inject) begin
         repeat (300) @(negedge clk);
         phy_first_i = first ^ 5'd5; phy_last_i = last ^ 5'd3;
         adv_a_i = ~a; adv_b_i = ~b;
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
         phy_first_i = first; phy_last_i = last; adv_a_i = a; adv_b_i = b;
      end
      waited = 0;
      while (!done_o && waited < limit) begin
         @(negedge clk);
         waited++;
      end
      chk(done_o, "R8 done after last PHY", 64'(done_o), 64'd1);
      repeat (3 * 68 * DIV) @(negedge clk);
      chk(nfr - base == 3 * nphy, inject ? "R9 frame count despite start" : "R4 frame count",
          64'(nfr - base), 64'(3 * nphy));
      chk(done_o && !mdio_oe_o, "R7 done holds, oe low", {62'd0, done_o, mdio_oe_o}, 64'd2);
      for (int p = 0; p < nphy; p++) begin
         for (int s = 0; s < 3; s++) begin
            logic [63:0] f;
            logic [4:0]  ephy, ereg;
            logic [15:0] edat;
            int idx;
            idx  = base + 3 * p + s;
            f    = (idx < 64) ? frames[idx] : '0;
            ephy = 5'((int'(first) + p) & 31);
            ereg = (s == 0) ? 5'd4 : (s == 1) ? 5'd5 : 5'd0;
            edat = (s == 0) ? a : (s == 1) ? b : 16'h1200;
            chk(f[63:28] == {32'hffff_ffff, 4'b0101} && f[17:16] == 2'b10, "R1 frame header",
                {f[63:28], f[17:16]}, {32'hffff_ffff, 4'b0101, 2'b10});
            chk(f[27:23] == ephy, "R4 PHY address order", 64'(f[27:23]), 64'(ephy));
            chk({f[22:18], f[15:0]} == {ereg, edat}, (s == 2) ? "R3 restart write" : "R2 ability write",
                64'({f[22:18], f[15:0]}), 64'({ereg, edat}));
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!mdc_o && !mdio_oe_o && !done_o, "R10 reset outputs", {61'd0, mdc_o, mdio_oe_o, done_o}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!mdio_oe_o && !done_o, "R10 after reset", {62'd0, mdio_oe_o, done_o}, 64'd0);
      run_seq(5'd2, 5'd4, 16'h01e1, 16'h45e1, 1'b0);
      run_seq(5'd30, 5'd1, 16'hA5C3, 16'h5A3C, 1'b1);
      run_seq(5'd7, 5'd7, 16'hFFFF, 16'h0000, 1'b0);
      run_seq(5'd0, 5'd1, 16'h8001, 16'h7FFE, 1'b0);
      chk(stab_bad == 0, "R6 MDIO stable while MDC high", 64'(stab_bad), 64'd0);
      chk(period_bad == 0, "R5 MDC period and duty", 64'(period_bad), 64'd0);
      chk(gap_bad == 0, "R7 idle gap between frames", 64'(gap_bad), 64'd0);
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++; bad++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule